// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers 96 level-sensitive interrupt sources into three groups of 32: a primary low group (numbers 0–31), a primary high group (32–63) and a pin group (64–95). Every group has a cause word and an enable mask. Software reaches them through a small register port that has two windows: the primary window and the pin window. The pin group does not raise the request line itself. Its enabled pending bits are folded into four summary bits inside the high cause word, so a pin event travels through the high group's mask on its way out.

A single request line goes high while enabled work is pending in the low or high group. A select-cause word tells the handler which primary half to service. A built-in resolver also produces a 7-bit interrupt number for the winning source, with a valid flag, so a handler can skip the scan. Primary cause bits follow their inputs one clock late. Pin cause bits are sticky and are cleared by writing zeros.

Top module: `casc_irq_ctrl_top`

## Requirements
- R1: After reset the low mask and pin mask read 0, the high mask reads 0x0F000000, and every cause word reads 0 while the sources are low; irqOut and vecValid are 0.
- R2: The low cause (primary 0x04) and high cause (primary 0x0C) show srcIn[31:0] and srcIn[63:32] as they were at the previous clock edge. Writes to either offset have no effect.
- R3: High cause bit 24+k (k = 0..3) is the OR of the enabled pin cause bits 8k..8k+7. srcIn[59:56] has no effect on anything.
- R4: A pin cause bit (pin window 0x08) is set at a clock edge where its input srcIn[64+p] is high. It stays set after the input falls.
- R5: A write to the pin cause word clears each bit written as 0 and keeps each bit written as 1. An input that is still high sets its bit again in the same edge.
- R6: The low mask (primary 0x14), high mask (primary 0x1C) and pin mask (pin window 0x0C) read back the last value written. Unmapped offsets read 0.
- R7: The select-cause word (primary 0x24) returns the low cause with bit 30 forced to 0 when enabled low work is pending or nothing is pending. Otherwise it returns the high cause with bit 30 forced to 1.
- R8: vecNum carries the group in bits 6:5 (0 low, 1 high, 2 pin) and the bit position in bits 4:0. The highest-numbered enabled pending bit in the group wins. The low group wins over the high group, and group code 3 is never produced.
- R9: When any of the enabled high bits 24–27 is set, the number is 64 plus the highest enabled pending pin bit.
- R10: vecValid and irqOut are 1 exactly when the low or high cause, ANDed with its mask, is nonzero. Clearing a high mask bit in 24–27 hides the pin events behind that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWin | input | 1 | Register window select: 0 primary, 1 pin group |
| regAddr | input | 8 | Byte offset within the window |
| regWr | input | 1 | Write strobe, takes effect at the clock edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the addressed register, combinational |
| srcIn | input | 96 | Level interrupt sources, bit n is interrupt n |
| irqOut | output | 1 | Interrupt request |
| vecValid | output | 1 | vecNum holds a resolved source |
| vecNum | output | 7 | Resolved interrupt number |

## Verification
Source changes and register writes reach the state at the next rising edge. From there, irqOut, vecValid, vecNum and the read data follow through logic only, so each result is due exactly one edge after its stimulus. The bench drives every stimulus at a falling edge and samples just after the following falling edge. Reads change only the combinational read path, so each read sets the window and offset at a falling edge and compares a moment later, with no edge in between. A bench model of the sticky pin word is updated from the bench's own driven signals at the same edge as the design.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;
  localparam int GRP_W    = 32;
  localparam int GRP_CNT  = 3;
  localparam int IDX_W    = $clog2(GRP_W);
  localparam int VEC_W    = IDX_W + 2;
  localparam int SRC_W    = GRP_W * GRP_CNT;
  localparam int SUM_LSB  = 24;
  localparam int SUM_CNT  = 4;
  localparam int SUM_SPAN = GRP_W / SUM_CNT;
  localparam int SEL_FLAG = 30;

  localparam logic [GRP_W-1:0] HIGH_MASK_RST = {{(GRP_W-SUM_LSB-SUM_CNT){1'b0}}, {SUM_CNT{1'b1}}, {SUM_LSB{1'b0}}};
  localparam logic [GRP_W-1:0] SUM_FIELD     = HIGH_MASK_RST;

  // primary window offsets
  localparam logic [7:0] OFF_LOW_CAUSE  = 8'h04;
  localparam logic [7:0] OFF_HIGH_CAUSE = 8'h0C;
  localparam logic [7:0] OFF_LOW_MASK   = 8'h14;
  localparam logic [7:0] OFF_HIGH_MASK  = 8'h1C;
  localparam logic [7:0] OFF_SELECT     = 8'h24;
  // pin window offsets
  localparam logic [7:0] OFF_PIN_CAUSE  = 8'h08;
  localparam logic [7:0] OFF_PIN_MASK   = 8'h0C;

  typedef enum logic [1:0] {
    GRP_LOW  = 2'd0,
    GRP_HIGH = 2'd1,
    GRP_PIN  = 2'd2
  } grpCode_e;

  typedef enum logic [2:0] {
    RD_NONE, RD_LOW_CAUSE, RD_HIGH_CAUSE, RD_LOW_MASK,
    RD_HIGH_MASK, RD_SELECT, RD_PIN_CAUSE, RD_PIN_MASK
  } rdSel_e;

  typedef struct packed {
    logic wrLowMask;
    logic wrHighMask;
    logic wrPinMask;
    logic wrPinCause;
  } ctlStrb_t;
endpackage

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import casc_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regWin,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  output ctlStrb_t          strb,
  output rdSel_e            rdSel
);
  always_comb begin
    strb  = '0;
    rdSel = RD_NONE;
    if (!regWin) begin
      case (regAddr)
        ADDR_W'(OFF_LOW_CAUSE):  rdSel = RD_LOW_CAUSE;
        ADDR_W'(OFF_HIGH_CAUSE): rdSel = RD_HIGH_CAUSE;
        ADDR_W'(OFF_LOW_MASK): begin
          rdSel          = RD_LOW_MASK;
          strb.wrLowMask = regWr;
        end
        ADDR_W'(OFF_HIGH_MASK): begin
          rdSel           = RD_HIGH_MASK;
          strb.wrHighMask = regWr;
        end
        ADDR_W'(OFF_SELECT):     rdSel = RD_SELECT;
        default:                 rdSel = RD_NONE;
      endcase
    end else begin
      case (regAddr)
        ADDR_W'(OFF_PIN_CAUSE): begin
          rdSel           = RD_PIN_CAUSE;
          strb.wrPinCause = regWr;
        end
        ADDR_W'(OFF_PIN_MASK): begin
          rdSel          = RD_PIN_MASK;
          strb.wrPinMask = regWr;
        end
        default:                rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/casc_irq_dp.sv
module casc_irq_dp
  import casc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  rdSel_e           rdSel,
  input  logic [GRP_W-1:0] regWrData,
  input  logic [SRC_W-1:0] srcIn,
  output logic [GRP_W-1:0] regRdData,
  output logic [GRP_W-1:0] lowMasked,
  output logic [GRP_W-1:0] highMasked,
  output logic [GRP_W-1:0] pinMasked,
  output logic             irqOut
);
  logic [GRP_W-1:0]   lowCause, highRaw, pinCause;
  logic [GRP_W-1:0]   lowMask, highMask, pinMask;
  logic [GRP_W-1:0]   highCause, selectWord;
  logic [SUM_CNT-1:0] pinSum;
  logic               lowPend, highPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCause <= '0;
      highRaw  <= '0;
      pinCause <= '0;
      lowMask  <= '0;
      highMask <= HIGH_MASK_RST;
      pinMask  <= '0;
    end else begin
      lowCause <= srcIn[GRP_W-1:0];
      highRaw  <= srcIn[2*GRP_W-1:GRP_W] & ~SUM_FIELD;
      pinCause <= (strb.wrPinCause ? (pinCause & regWrData) : pinCause)
                  | srcIn[3*GRP_W-1:2*GRP_W];
      if (strb.wrLowMask)  lowMask  <= regWrData;
      if (strb.wrHighMask) highMask <= regWrData;
      if (strb.wrPinMask)  pinMask  <= regWrData;
    end
  end

  assign pinMasked = pinCause & pinMask;

  for (genvar k = 0; k < SUM_CNT; k++) begin : gSum
    assign pinSum[k] = |pinMasked[k*SUM_SPAN +: SUM_SPAN];
  end

  assign highCause  = highRaw | (GRP_W'(pinSum) << SUM_LSB);
  assign lowMasked  = lowCause & lowMask;
  assign highMasked = highCause & highMask;
  assign lowPend    = |lowMasked;
  assign highPend   = |highMasked;
  assign irqOut     = lowPend | highPend;

  always_comb begin
    selectWord = lowCause;
    selectWord[SEL_FLAG] = 1'b0;
    if (!lowPend && highPend) begin
      selectWord = highCause;
      selectWord[SEL_FLAG] = 1'b1;
    end
  end

  always_comb begin
    case (rdSel)
      RD_LOW_CAUSE:  regRdData = lowCause;
      RD_HIGH_CAUSE: regRdData = highCause;
      RD_LOW_MASK:   regRdData = lowMask;
      RD_HIGH_MASK:  regRdData = highMask;
      RD_SELECT:     regRdData = selectWord;
      RD_PIN_CAUSE:  regRdData = pinCause;
      RD_PIN_MASK:   regRdData = pinMask;
      default:       regRdData = '0;
    endcase
  end

  // R4
  pin_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPinCause |=> ((pinCause & $past(pinCause)) == $past(pinCause)));

  // R5
  pin_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPinCause |=> ((pinCause & ~$past(regWrData)) ==
                         ($past(srcIn[3*GRP_W-1:2*GRP_W]) & ~$past(regWrData))));

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R2
  low_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (lowCause == $past(srcIn[GRP_W-1:0])));
endmodule

// File: rtl/casc_irq_resolve.sv
module casc_irq_resolve
  import casc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [GRP_W-1:0] lowMasked,
  input  logic [GRP_W-1:0] highMasked,
  input  logic [GRP_W-1:0] pinMasked,
  output logic             vecValid,
  output logic [VEC_W-1:0] vecNum
);
  logic [GRP_W-1:0] grpBits [GRP_CNT];
  logic [GRP_CNT-1:0] grpAny;
  logic [IDX_W-1:0] grpIdx [GRP_CNT];
  logic useCascade;

  assign grpBits[GRP_LOW]  = lowMasked;
  assign grpBits[GRP_HIGH] = highMasked;
  assign grpBits[GRP_PIN]  = pinMasked;

  for (genvar g = 0; g < GRP_CNT; g++) begin : gEnc
    always_comb begin
      grpAny[g] = |grpBits[g];
      grpIdx[g] = '0;
      for (int i = 0; i < GRP_W; i++) begin
        if (grpBits[g][i]) grpIdx[g] = IDX_W'(i);
      end
    end
  end

  assign useCascade = |highMasked[SUM_LSB +: SUM_CNT];

  always_comb begin
    vecValid = grpAny[GRP_LOW] | grpAny[GRP_HIGH];
    vecNum   = '0;
    if (grpAny[GRP_LOW])
      vecNum = {GRP_LOW, grpIdx[GRP_LOW]};
    else if (useCascade)
      vecNum = {GRP_PIN, grpIdx[GRP_PIN]};
    else if (grpAny[GRP_HIGH])
      vecNum = {GRP_HIGH, grpIdx[GRP_HIGH]};
  end

  // R8
  group_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecNum[VEC_W-1 -: 2] != 2'd3));

  // R8
  low_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && vecNum[VEC_W-1 -: 2] == 2'd0) |->
      ((lowMasked >> vecNum[IDX_W-1:0]) == GRP_W'(1)));

  // R9
  pin_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && vecNum[VEC_W-1 -: 2] == 2'd2) |->
      ((pinMasked >> vecNum[IDX_W-1:0]) == GRP_W'(1)));
endmodule

// File: rtl/casc_irq_ctrl_top.sv
module casc_irq_ctrl_top
  import casc_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWin,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [GRP_W-1:0]  regWrData,
  output logic [GRP_W-1:0]  regRdData,
  input  logic [SRC_W-1:0]  srcIn,
  output logic              irqOut,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecNum
);
  ctlStrb_t         strb;
  rdSel_e           rdSel;
  logic [GRP_W-1:0] lowMasked, highMasked, pinMasked;

  casc_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regWin(regWin), .regAddr(regAddr), .regWr(regWr),
    .strb(strb), .rdSel(rdSel)
  );

  casc_irq_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel),
    .regWrData(regWrData), .srcIn(srcIn), .regRdData(regRdData),
    .lowMasked(lowMasked), .highMasked(highMasked), .pinMasked(pinMasked),
    .irqOut(irqOut)
  );

  casc_irq_resolve res_i (
    .clk(clk), .rstN(rstN), .lowMasked(lowMasked), .highMasked(highMasked),
    .pinMasked(pinMasked), .vecValid(vecValid), .vecNum(vecNum)
  );

  // R10
  req_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == vecValid);
endmodule

// File: tb/casc_irq_ctrl_top_tb.sv
`timescale 1ns/1ps
module casc_irq_ctrl_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWin = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [95:0] src = '0;
  logic        irqOut, vecValid;
  logic [6:0]  vecNum;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mLowMask = '0, mHighMask = 32'h0F00_0000, mPinMask = '0, mPin = '0;

  always #4 clk = ~clk;

  casc_irq_ctrl_top dut_i (
    .clk(clk), .rstN(rstN), .regWin(regWin), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .srcIn(src),
    .irqOut(irqOut), .vecValid(vecValid), .vecNum(vecNum)
  );

  // sticky pin model driven from the bench's own stimulus
  always @(posedge clk) begin
    if (!rstN) mPin <= '0;
    else if (regWr && regWin && regAddr == 8'h08) mPin <= (mPin & regWrData) | src[95:64];
    else mPin <= mPin | src[95:64];
  end

  function automatic int topBit(logic [31:0] v);
    int r = -1;
    for (int i = 0; i < 32; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [31:0] expHigh();
    logic [31:0] pm = mPin & mPinMask;
    logic [31:0] h = src[63:32];
    for (int k = 0; k < 4; k++) h[24+k] = (pm[8*k +: 8] != 0);
    return h;
  endfunction

  function automatic logic [31:0] expSel();
    logic [31:0] lm = src[31:0] & mLowMask;
    logic [31:0] hm = expHigh() & mHighMask;
    logic [31:0] w;
    if (lm != 0 || hm == 0) begin w = src[31:0]; w[30] = 1'b0; end
    else begin w = expHigh(); w[30] = 1'b1; end
    return w;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic checkOut(string req);
    logic [31:0] lm = src[31:0] & mLowMask;
    logic [31:0] hm = expHigh() & mHighMask;
    logic [31:0] pm = mPin & mPinMask;
    logic ev = (lm != 0) || (hm != 0);
    int en = 0;
    if (lm != 0) en = topBit(lm);
    else if (hm[27:24] != 0) en = 64 + topBit(pm);
    else if (hm != 0) en = 32 + topBit(hm);
    chk(vecValid === ev && irqOut === ev, req, {30'd0, irqOut, vecValid}, {30'd0, ev, ev});
    if (ev) chk(vecNum === 7'(en), req, 32'(vecNum), 32'(en));
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic wrReg(logic win, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWin = win; regAddr = a; regWrData = d; regWr = 1'b1;
    @(posedge clk);
    if (!win && a == 8'h14) mLowMask = d;
    if (!win && a == 8'h1C) mHighMask = d;
    if (win && a == 8'h0C) mPinMask = d;
    @(negedge clk);
    regWr = 1'b0;
    #1;
  endtask

  task automatic rdChk(logic win, logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    regWin = win; regAddr = a;
    #1;
    chk(regRdData === exp, req, regRdData, exp);
  endtask

  task automatic setSrc(logic [95:0] v);
    @(negedge clk);
    src = v;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    tick();
    // R1 reset state
    rdChk(0, 8'h04, 32'h0, "R1 low cause");
    rdChk(0, 8'h0C, 32'h0, "R1 high cause");
    rdChk(0, 8'h14, 32'h0, "R1 low mask");
    rdChk(0, 8'h1C, 32'h0F00_0000, "R1 high mask");
    rdChk(1, 8'h08, 32'h0, "R1 pin cause");
    rdChk(1, 8'h0C, 32'h0, "R1 pin mask");
    rdChk(0, 8'h24, 32'h0, "R1 select");
    checkOut("R1 outputs");

    // R6 masks and unmapped offsets
    wrReg(0, 8'h14, 32'hA5A5_0F0F);
    rdChk(0, 8'h14, 32'hA5A5_0F0F, "R6 low mask");
    wrReg(0, 8'h1C, 32'h1234_5678);
    rdChk(0, 8'h1C, 32'h1234_5678, "R6 high mask");
    wrReg(1, 8'h0C, 32'hDEAD_BEEF);
    rdChk(1, 8'h0C, 32'hDEAD_BEEF, "R6 pin mask");
    rdChk(0, 8'h10, 32'h0, "R6 unmapped");
    wrReg(0, 8'h14, 32'hFFFF_FFFF);
    wrReg(0, 8'h1C, 32'hFFFF_FFFF);
    wrReg(1, 8'h0C, 32'hFFFF_FFFF);

    // R2 R8 low sweep, single and pairs
    for (int i = 0; i < 32; i++) begin
      setSrc(96'(1) << i);
      checkOut("R8 low single");
      rdChk(0, 8'h04, 32'(1) << i, "R2 low cause");
      setSrc((96'(1) << i) | (96'(1) << ((i + 11) % 32)));
      checkOut("R8 low pair");
    end
    // R2 writes to cause offsets ignored
    setSrc(96'h0000_0000_0000_0000_0000_0100);
    wrReg(0, 8'h04, 32'hFFFF_0000);
    rdChk(0, 8'h04, 32'h0000_0100, "R2 low cause write ignored");
    checkOut("R2 after cause write");

    // R3 R8 high sweep; bits 24..27 of the high input are ignored
    for (int i = 0; i < 32; i++) begin
      setSrc(96'(1) << (32 + i));
      checkOut("R8 R3 high single");
      rdChk(0, 8'h0C, (i >= 24 && i <= 27) ? 32'h0 : (32'(1) << i), "R2 R3 high cause");
      rdChk(0, 8'h24, expSel(), "R7 select high");
    end
    wrReg(0, 8'h0C, 32'hFFFF_FFFF);
    rdChk(0, 8'h0C, 32'h8000_0000, "R2 high cause write ignored");

    // R7 R8 both halves pending: low wins
    setSrc({32'h0, 32'h0040_0001, 32'h0000_0200});
    checkOut("R8 low over high");
    rdChk(0, 8'h24, 32'h0000_0200, "R7 select low first");
    setSrc({32'h0, 32'h4000_0000, 32'h0});
    rdChk(0, 8'h24, 32'h4000_0000, "R7 select high flag");

    // R4 R5 R9 pin sweep
    for (int p = 0; p < 32; p++) begin
      setSrc(96'(1) << (64 + p));
      setSrc('0);
      checkOut("R4 R9 pin sticky");
      rdChk(1, 8'h08, 32'(1) << p, "R4 pin cause");
      rdChk(0, 8'h0C, 32'(1) << (24 + p / 8), "R3 summary");
      wrReg(1, 8'h08, 32'hFFFF_FFFF);
      rdChk(1, 8'h08, 32'(1) << p, "R5 ones keep");
      wrReg(1, 8'h08, ~(32'(1) << p));
      rdChk(1, 8'h08, 32'h0, "R5 zero clears");
      checkOut("R5 after clear");
    end
    // R9 highest pin wins; R5 live input survives clear
    setSrc({32'h0081_0004, 64'h0});
    setSrc({32'h0001_0000, 64'h0});
    checkOut("R9 pin top bit");
    wrReg(1, 8'h08, 32'h0);
    rdChk(1, 8'h08, 32'h0001_0000, "R5 input wins");
    checkOut("R9 after partial clear");
    setSrc('0);
    wrReg(1, 8'h08, 32'h0);

    // R10 masking
    wrReg(0, 8'h14, 32'h0);
    setSrc({32'h0, 32'h0, 32'hFFFF_FFFF});
    checkOut("R10 low masked off");
    chk(vecValid === 1'b0, "R10 low masked", 32'(vecValid), 32'h0);
    setSrc({32'h0000_0100, 32'h0, 32'h0});
    wrReg(0, 8'h1C, 32'hF0FF_FFFF);
    checkOut("R10 summary masked");
    chk(irqOut === 1'b0, "R10 pin hidden", 32'(irqOut), 32'h0);
    wrReg(1, 8'h0C, 32'h0);
    wrReg(0, 8'h1C, 32'hFFFF_FFFF);
    checkOut("R10 pin mask off");
    chk(irqOut === 1'b0, "R10 pin mask zero", 32'(irqOut), 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule